// File: doc/BRIEF.md
# Serial Audio Clock Error Monitor

This block watches the bit clock and frame sync of a TDM serial audio port. It samples both signals with a faster reference clock. For every frame it counts how many bit clocks arrive between two rising edges of frame sync, and how many reference cycles the frame lasts. A frame is rejected when its bit-clock count is not one of the supported ratios, or when its length in reference cycles lies outside a programmed window. The block also reports an error when either serial clock stops toggling for longer than a programmed limit, and when a frame changes its ratio or its length compared with the frame before.

Any of these errors raises a shutdown request in the same reference cycle in which the error is found. The amplifier uses this request to go quickly to software shutdown. The block clears the request only after two valid frames in a row with the same ratio and the same length. It then gives a one-cycle ramp-back request, so that the volume engine can return to the playback level it had before. Three sticky flags record why the fault happened: an invalid ratio or rate, a rate change while running, and a ratio change while running. They stay set until software clears them.

Top module: `tdm_clk_mon`

## Requirements
- R1: After reset, `shutdown_req`, `rampback_req`, `clk_halted` and all three sticky flags are 0.
- R2: A frame whose bit-clock count (rising bit-clock edges between two frame-sync rising edges) is not one of 16, 24, 32, 48, 64, 96, 128, 192, 256, 512 raises `shutdown_req` and sets `stk_inv`.
- R3: When either serial input has had no edge for `halt_limit` reference cycles, `clk_halted` is 1 and `shutdown_req` is 1.
- R4: A frame whose length in reference cycles is below `per_min` or above `per_max` raises `shutdown_req` and sets `stk_inv`.
- R5: `shutdown_req` rises in the same reference cycle in which a frame-sync edge shows an error. It does not wait for the end of the next frame.
- R6: The fault clears only after two consecutive valid frames with equal ratio and lengths within `PER_TOL` (default 2) reference cycles of each other. One valid frame is not enough. On clearing, `rampback_req` is high for exactly one cycle.
- R7: A valid frame whose ratio differs from the previous valid frame sets `stk_ratio_chg` and raises `shutdown_req`. It does not set `stk_rate_chg` when the length is unchanged.
- R8: A valid frame whose length differs by more than `PER_TOL` from the previous valid frame sets `stk_rate_chg`. It does not set `stk_ratio_chg` when the ratio is unchanged.
- R9: The sticky flags stay set after the fault has cleared. They return to 0 only on `sticky_clr`.
- R10: The first frame after reset or after a clock halt serves only as the reference for later frames. A new ratio at that point does not set a change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| fsync_in | input | 1 | Frame sync, asynchronous |
| per_min | input | PER_W | Shortest allowed frame, in reference cycles |
| per_max | input | PER_W | Longest allowed frame, in reference cycles |
| halt_limit | input | PER_W | Reference cycles without an edge before a clock counts as halted |
| sticky_clr | input | 1 | Clears the three sticky flags |
| shutdown_req | output | 1 | Request for fast software shutdown |
| rampback_req | output | 1 | One-cycle request to ramp volume back |
| clk_halted | output | 1 | Live flag: a serial clock has stopped |
| stk_inv | output | 1 | Sticky: invalid ratio or frame rate seen |
| stk_rate_chg | output | 1 | Sticky: frame length changed while running |
| stk_ratio_chg | output | 1 | Sticky: ratio changed while running |

## Verification
The hardest state to reach from the ports is one in which exactly one cause is present. Two examples are a ratio change with the frame length held constant, and a fault that stays set after only one good frame. The stimulus reaches the first case by halving the bit-clock half period while doubling the ratio, so the frame length in reference cycles stays the same. It reaches the second case by ending a run of bad frames with exactly two good frames, then adding a third. To check how fast the request arrives, the bench samples the shutdown request in the middle of a frame, a few reference cycles after the frame-sync edge that carries a rate change.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  localparam int unsigned NUM_RATIOS = 10;
  localparam int unsigned RATIO_SET [NUM_RATIOS] =
    '{16, 24, 32, 48, 64, 96, 128, 192, 256, 512};

  // bit clocks per frame is one of the supported ratios
  function automatic logic ratio_ok(input int unsigned n);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (RATIO_SET[i] == n) hit = 1'b1;
    end
    return hit;
  endfunction

  // frame length (reference cycles) inside the programmed window
  function automatic logic period_ok(input int unsigned p,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (p >= lo) && (p <= hi);
  endfunction

  // two frame lengths agree within a tolerance
  function automatic logic period_match(input int unsigned a,
                                        input int unsigned b,
                                        input int unsigned tol);
    int unsigned d;
    d = (a > b) ? (a - b) : (b - a);
    return d <= tol;
  endfunction

endpackage

// File: rtl/tcm_edge_sync.sv
module tcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic edge_any
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise     = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign edge_any = sh_q[STAGES-1] ^ sh_q[STAGES];
endmodule

// File: rtl/tcm_halt_timer.sv
module tcm_halt_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_seen,
  input  logic [W-1:0] limit,
  output logic         halted
);
  localparam logic [W-1:0] CNT_MAX = '1;
  logic [W-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               idle_q <= '0;
    else if (edge_seen)       idle_q <= '0;
    else if (idle_q != CNT_MAX) idle_q <= idle_q + W'(1);
  end

  assign halted = (idle_q >= limit);
endmodule

// File: rtl/tcm_frame_meas.sv
module tcm_frame_meas
  import tcm_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int PER_W   = 16,
  parameter int PER_TOL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_rise,
  input  logic             fs_rise,
  input  logic             halted,
  input  logic [PER_W-1:0] per_min,
  input  logic [PER_W-1:0] per_max,
  output logic             frm_bad_evt,
  output logic             ratio_chg_evt,
  output logic             rate_chg_evt,
  output logic             frm_match_evt
);
  localparam int RW = CNT_W + 1;
  localparam int PW = PER_W + 1;
  localparam logic [CNT_W-1:0] BC_MAX = '1;
  localparam logic [PER_W-1:0] PC_MAX = '1;

  logic [CNT_W-1:0] bclk_cnt_q;
  logic [PER_W-1:0] per_cnt_q;
  logic             armed_q;
  logic             prev_ok_q;
  logic [RW-1:0]    prev_ratio_q;
  logic [PW-1:0]    prev_per_q;

  logic [RW-1:0] cur_ratio;
  logic [PW-1:0] cur_per;
  logic          frame_evt, frm_valid, same_ratio, same_per;

  assign cur_ratio  = {1'b0, bclk_cnt_q} + RW'(bclk_rise);
  assign cur_per    = {1'b0, per_cnt_q} + PW'(1);
  assign frame_evt  = fs_rise & armed_q & ~halted;
  assign frm_valid  = ratio_ok(32'(cur_ratio)) &
                      period_ok(32'(cur_per), 32'(per_min), 32'(per_max));
  assign same_ratio = (cur_ratio == prev_ratio_q);
  assign same_per   = period_match(32'(cur_per), 32'(prev_per_q), PER_TOL);

  assign frm_bad_evt   = frame_evt & ~frm_valid;
  assign ratio_chg_evt = frame_evt & frm_valid & prev_ok_q & ~same_ratio;
  assign rate_chg_evt  = frame_evt & frm_valid & prev_ok_q & ~same_per;
  assign frm_match_evt = frame_evt & frm_valid & prev_ok_q & same_ratio & same_per;

  always_ff @(posedge clk) begin
    if (!rst_n || halted) begin
      bclk_cnt_q   <= '0;
      per_cnt_q    <= '0;
      armed_q      <= 1'b0;
      prev_ok_q    <= 1'b0;
      prev_ratio_q <= '0;
      prev_per_q   <= '0;
    end else if (fs_rise) begin
      bclk_cnt_q <= '0;
      per_cnt_q  <= '0;
      armed_q    <= 1'b1;
      if (armed_q) begin
        prev_ok_q    <= frm_valid;
        prev_ratio_q <= cur_ratio;
        prev_per_q   <= cur_per;
      end
    end else begin
      if (bclk_rise && bclk_cnt_q != BC_MAX) bclk_cnt_q <= bclk_cnt_q + CNT_W'(1);
      if (per_cnt_q != PC_MAX)               per_cnt_q  <= per_cnt_q + PER_W'(1);
    end
  end
endmodule

// File: rtl/tcm_err_ctrl.sv
module tcm_err_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_bad_evt,
  input  logic ratio_chg_evt,
  input  logic rate_chg_evt,
  input  logic frm_match_evt,
  input  logic halted,
  input  logic sticky_clr,
  output logic err_evt,
  output logic shutdown_req,
  output logic rampback_req,
  output logic stk_inv,
  output logic stk_rate_chg,
  output logic stk_ratio_chg
);
  logic fault_q, ramp_q;

  assign err_evt      = frm_bad_evt | ratio_chg_evt | rate_chg_evt | halted;
  assign shutdown_req = fault_q | err_evt;
  assign rampback_req = ramp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      ramp_q  <= 1'b0;
    end else begin
      ramp_q <= 1'b0;
      if (!fault_q) begin
        if (err_evt) fault_q <= 1'b1;
      end else if (frm_match_evt && !halted) begin
        fault_q <= 1'b0;
        ramp_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk_inv       <= 1'b0;
      stk_rate_chg  <= 1'b0;
      stk_ratio_chg <= 1'b0;
    end else begin
      stk_inv       <= (stk_inv       & ~sticky_clr) | frm_bad_evt;
      stk_rate_chg  <= (stk_rate_chg  & ~sticky_clr) | rate_chg_evt;
      stk_ratio_chg <= (stk_ratio_chg & ~sticky_clr) | ratio_chg_evt;
    end
  end
endmodule

// File: rtl/tdm_clk_mon.sv
module tdm_clk_mon #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 10,
  parameter int PER_W       = 16,
  parameter int PER_TOL     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk_in,
  input  logic             fsync_in,
  input  logic [PER_W-1:0] per_min,
  input  logic [PER_W-1:0] per_max,
  input  logic [PER_W-1:0] halt_limit,
  input  logic             sticky_clr,
  output logic             shutdown_req,
  output logic             rampback_req,
  output logic             clk_halted,
  output logic             stk_inv,
  output logic             stk_rate_chg,
  output logic             stk_ratio_chg
);
  localparam int NUM_CLK = 2;

  logic [NUM_CLK-1:0] raw_in, rise_v, edge_v, halt_v;
  logic frm_bad_evt, ratio_chg_evt, rate_chg_evt, frm_match_evt, err_evt;

  assign raw_in = {fsync_in, bclk_in};

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_clk
    tcm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(raw_in[g]),
      .rise(rise_v[g]), .edge_any(edge_v[g]));
    tcm_halt_timer #(.W(PER_W)) halt_i (
      .clk(clk), .rst_n(rst_n), .edge_seen(edge_v[g]),
      .limit(halt_limit), .halted(halt_v[g]));
  end

  assign clk_halted = |halt_v;

  tcm_frame_meas #(.CNT_W(CNT_W), .PER_W(PER_W), .PER_TOL(PER_TOL)) meas_i (
    .clk(clk), .rst_n(rst_n),
    .bclk_rise(rise_v[0]), .fs_rise(rise_v[1]), .halted(clk_halted),
    .per_min(per_min), .per_max(per_max),
    .frm_bad_evt(frm_bad_evt), .ratio_chg_evt(ratio_chg_evt),
    .rate_chg_evt(rate_chg_evt), .frm_match_evt(frm_match_evt));

  tcm_err_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .frm_bad_evt(frm_bad_evt), .ratio_chg_evt(ratio_chg_evt),
    .rate_chg_evt(rate_chg_evt), .frm_match_evt(frm_match_evt),
    .halted(clk_halted), .sticky_clr(sticky_clr), .err_evt(err_evt),
    .shutdown_req(shutdown_req), .rampback_req(rampback_req),
    .stk_inv(stk_inv), .stk_rate_chg(stk_rate_chg), .stk_ratio_chg(stk_ratio_chg));
endmodule

// File: rtl/tdm_clk_mon_chk.sv
module tdm_clk_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic err_evt,
  input logic ratio_chg_evt,
  input logic rate_chg_evt,
  input logic shutdown_req,
  input logic rampback_req,
  input logic clk_halted,
  input logic sticky_clr,
  input logic stk_ratio_chg,
  input logic stk_rate_chg
);
  AST_RST_QUIET: assert property (@(posedge clk) !rst_n |=> !rampback_req); // R1
  AST_HALT_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n) clk_halted |-> shutdown_req); // R3
  AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(shutdown_req) |-> err_evt); // R5
  AST_SHUTDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) err_evt |=> shutdown_req); // R5
  AST_RAMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rampback_req |=> !rampback_req); // R6
  AST_RAMP_FROM_FAULT: assert property (@(posedge clk) disable iff (!rst_n) rampback_req |-> $past(shutdown_req)); // R6
  AST_RATIO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ratio_chg_evt |=> stk_ratio_chg); // R7
  AST_RATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rate_chg_evt |=> stk_rate_chg); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (stk_ratio_chg && !sticky_clr) |=> stk_ratio_chg); // R9
endmodule

bind tdm_clk_mon tdm_clk_mon_chk chk_i (
  .clk(clk), .rst_n(rst_n), .err_evt(err_evt),
  .ratio_chg_evt(ratio_chg_evt), .rate_chg_evt(rate_chg_evt),
  .shutdown_req(shutdown_req), .rampback_req(rampback_req),
  .clk_halted(clk_halted), .sticky_clr(sticky_clr),
  .stk_ratio_chg(stk_ratio_chg), .stk_rate_chg(stk_rate_chg));

// File: tb/tdm_clk_mon_tb_top.sv
module tdm_clk_mon_tb_top;
  localparam int PER_W = 16;
  localparam int NROWS = 9;
  // half period (ref cycles), ratio, expected fault
  localparam int TBL [NROWS][3] = '{
    '{2, 32, 0}, '{2, 64, 0}, '{2, 48, 0}, '{1, 128, 0}, '{2, 24, 1},
    '{3, 20, 1}, '{4, 36, 1}, '{5, 32, 1}, '{1, 96, 0}};

  logic clk = 1'b0;
  logic rst_n, bclk, fsync, sticky_clr;
  logic [PER_W-1:0] per_min = 16'd100, per_max = 16'd300, halt_limit = 16'd400;
  logic shutdown_req, rampback_req, clk_halted, stk_inv, stk_rate_chg, stk_ratio_chg;
  int n_chk = 0, n_bad = 0, ramp_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tdm_clk_mon dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .fsync_in(fsync),
    .per_min(per_min), .per_max(per_max), .halt_limit(halt_limit),
    .sticky_clr(sticky_clr), .shutdown_req(shutdown_req),
    .rampback_req(rampback_req), .clk_halted(clk_halted), .stk_inv(stk_inv),
    .stk_rate_chg(stk_rate_chg), .stk_ratio_chg(stk_ratio_chg));

  always @(posedge clk) if (rampback_req) ramp_cnt <= ramp_cnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ref(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bclk = 1'b0; fsync = 1'b0; sticky_clr = 1'b0;
    wait_ref(5);
    rst_n = 1'b1;
  endtask

  // frames: fsync high during first bit clock, rises on a bclk falling edge
  task automatic run_frames(input int half, input int ratio, input int n, input bit probe);
    for (int f = 0; f < n; f++) begin
      for (int k = 0; k < ratio; k++) begin
        bclk = 1'b0; fsync = (k == 0);
        wait_ref(half);
        if (probe && f == 0 && k == 0)
          chk("R5 shutdown mid-frame after rate change", shutdown_req, 1);
        bclk = 1'b1;
        wait_ref(half);
      end
    end
  endtask

  initial begin
    int r0;
    do_reset();
    wait_ref(1);
    chk("R1 shutdown_req", shutdown_req, 0);
    chk("R1 rampback_req", rampback_req, 0);
    chk("R1 clk_halted", clk_halted, 0);
    chk("R1 stickies", {stk_inv, stk_rate_chg, stk_ratio_chg}, 0);

    // table walk: ratio (R2) and rate window (R4)
    for (int i = 0; i < NROWS; i++) begin
      do_reset();
      run_frames(TBL[i][0], TBL[i][1], 4, 1'b0);
      chk($sformatf("R2/R4 row %0d shutdown", i), shutdown_req, TBL[i][2]);
      chk($sformatf("R2/R4 row %0d stk_inv", i), stk_inv, TBL[i][2]);
    end

    // R3 halt, then R10 restart at a new ratio with no change flag
    do_reset();
    run_frames(2, 32, 4, 1'b0);
    wait_ref(500);
    chk("R3 clk_halted", clk_halted, 1);
    chk("R3 shutdown_req", shutdown_req, 1);
    r0 = ramp_cnt;
    run_frames(1, 64, 5, 1'b0);
    chk("R10 recovered after halt", shutdown_req, 0);
    chk("R10 no ratio change flag", stk_ratio_chg, 0);
    chk("R6 one rampback after halt", ramp_cnt - r0, 1);

    // R7 ratio change, length kept at 128 cycles
    do_reset();
    run_frames(2, 32, 4, 1'b0);
    r0 = ramp_cnt;
    run_frames(1, 64, 4, 1'b0);
    chk("R7 stk_ratio_chg", stk_ratio_chg, 1);
    chk("R7 stk_rate_chg stays 0", stk_rate_chg, 0);
    chk("R7 recovered", shutdown_req, 0);
    chk("R6 rampback pulse count", ramp_cnt - r0, 1);
    chk("R9 sticky kept after recovery", stk_ratio_chg, 1);
    @(negedge clk); sticky_clr = 1'b1;
    @(negedge clk); sticky_clr = 1'b0;
    chk("R9 sticky cleared", stk_ratio_chg, 0);

    // R8 rate change, ratio kept at 32; R5 probed mid-frame
    do_reset();
    run_frames(2, 32, 4, 1'b0);
    run_frames(3, 32, 1, 1'b0);
    run_frames(3, 32, 1, 1'b1);
    run_frames(3, 32, 2, 1'b0);
    chk("R8 stk_rate_chg", stk_rate_chg, 1);
    chk("R8 stk_ratio_chg stays 0", stk_ratio_chg, 0);
    chk("R8 stk_inv stays 0", stk_inv, 0);
    chk("R8 recovered", shutdown_req, 0);

    // R6 one good frame does not clear, the second matching one does
    do_reset();
    run_frames(2, 20, 3, 1'b0);
    r0 = ramp_cnt;
    run_frames(2, 32, 2, 1'b0);
    chk("R6 still in fault after one good frame", shutdown_req, 1);
    run_frames(2, 32, 1, 1'b0);
    chk("R6 cleared after two good frames", shutdown_req, 0);
    chk("R6 single rampback", ramp_cnt - r0, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule